// File: doc/BRIEF.md
# Vector Element Step and Query Unit

This unit keeps the walking position of a vector loop: a source element step, a destination element step, a sub-element step for each side, and two ordering flags, pack and unpack. One command at a time selects, through a 7-bit mode field, whether to move the position on to the next element, to report a step counter or one of four externally supplied shape indices, or to write the ordering flags. A commit bit decides whether a stepping command updates the state or only reports where it would go. A record bit asks for a 4-bit condition field derived from the result.

Element stepping honours a per-command predicate mask and vector length. Masked-out elements are skipped, so a step may jump by several elements. When the walk leaves its last unmasked element, the steps wrap to the first unmasked element and an end indication is raised. The sub-element step is normally the inner loop. The unpack flag makes the element step the inner loop on the source side, and the pack flag does the same on the destination side.

Commands enter on a valid/ready handshake. Results leave through a single output register on a valid/ready handshake. A command is accepted when the output register is empty or is being drained in the same cycle (`cmd_ready = !res_valid || res_ready`). While `res_valid` is high and `res_ready` is low, the result beat and `cmd_ready` stay frozen. All state, stepping and flag ports update on the clock edge that accepts the command, and the result appears on the same edge.

Top module: `vstep_unit`

## Requirements
- R1: A mode with bits [6:2] equal to 00011 is a flag write. It sets `pack_flag` to mode bit 0 and `unpack_flag` to mode bit 1, whatever the commit bit, and returns a result of 62 zero bits above {mode[1], mode[0]}.
- R2: Mode 0 with commit 1 advances both sides. Each side holds a step and a sub step, and the number of sub-elements is `cmd_sub_len`+1. Without swap, the sub step counts up first, and when it reaches its last value it returns to 0 while the element step moves on. With swap, the element step moves first, and the sub step counts up only when the element walk wraps. The source side swaps when `unpack_flag` is 1. The destination side swaps when `pack_flag` is 1.
- R3: An element counts as available when its predicate bit is 1 and its index is below `cmd_vec_len`. The element step moves to the lowest available index above the current step, skipping masked-out indices.
- R4: If no available index lies above the current step, the element step wraps to the lowest available index. If nothing is available at all, both steps and both sub steps become 0 and the end indication is raised. `res_end` is 1 when either side has finished its whole walk (element and sub), and 0 for every mode other than 0.
- R5: Mode 0 with commit 0 and record 1 returns the source step it would move to, but leaves every step, sub step and flag unchanged.
- R6: Mode 0 with commit 0 and record 0 is a no-operation. The command is accepted, no result beat is produced and no state changes.
- R7: Modes 1 to 4 return the index of shape generator 0 to 3, taken from `shape_idx` bits [7k+6:7k]. Mode 5 returns the source step and mode 6 the destination step. Every other mode value returns 0. None of these modes changes state.
- R8: The result for mode 0 is the new (or would-be) source step. Every stepping and query result has zero in bits [63:7].
- R9: `res_cr_vld` equals the record bit of the command. `res_cr` is {bit 3: result bit 63, bit 2: result non-zero and bit 63 clear, bit 1: result equal to zero, bit 0: end indication}.
- R10: While `res_valid` is 1 and `res_ready` is 0, `res_data`, `res_cr` and `res_end` hold and `cmd_ready` is 0. A new command can be accepted in the same cycle the held beat drains.
- R11: After reset, all steps, sub steps, flags and `res_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this cycle when valid |
| cmd_mode | input | 7 | Operation selector |
| cmd_commit | input | 1 | Update stepping state when 1 |
| cmd_record | input | 1 | Produce condition field |
| cmd_vec_len | input | 7 | Vector length, 0 to 64 |
| cmd_pred | input | 64 | Predicate, one bit per element |
| cmd_sub_len | input | 2 | Sub-elements per element minus one |
| shape_idx | input | 28 | Four 7-bit shape generator indices |
| res_valid | output | 1 | Result beat present |
| res_ready | input | 1 | Downstream takes the result |
| res_data | output | 64 | Result value |
| res_cr | output | 4 | Condition field |
| res_cr_vld | output | 1 | Condition field requested |
| res_end | output | 1 | End of walk indication |
| src_step | output | 7 | Source element step |
| dst_step | output | 7 | Destination element step |
| src_sub | output | 2 | Source sub-element step |
| dst_sub | output | 2 | Destination sub-element step |
| pack_flag | output | 1 | Destination ordering flag |
| unpack_flag | output | 1 | Source ordering flag |

## Verification
Two things can happen on one clock edge: a held result beat drains, and a new stepping command is accepted and reloads the output register and the step state. The bench provokes this by lowering `res_ready` after a committed step and keeping a second step command on the input. It checks that the first result and the step stay frozen and that `cmd_ready` stays low, then raises `res_ready`. It judges that the following edge yields exactly the second result with the step advanced once more. After that it checks that the output register empties on the next cycle, with no beat lost or repeated.

// File: rtl/vstep_pkg.sv
package vstep_pkg;

  typedef enum logic [2:0] {
    K_STEP,
    K_SHAPE,
    K_SRC,
    K_DST,
    K_FLAGS,
    K_OTHER
  } vstep_kind_e;

  // condition field: {negative, positive, zero, end}
  function automatic logic [3:0] mk_cr(input logic [63:0] val, input logic fin);
    logic neg;
    neg = val[63];
    mk_cr = {neg, (val != '0) && !neg, val == '0, fin};
  endfunction

endpackage

// File: rtl/vstep_prio.sv
module vstep_prio #(
  parameter int W     = 64,
  parameter int OUT_W = 7
) (
  input  logic [W-1:0]     vec,
  output logic [OUT_W-1:0] idx,
  output logic             found
);
  // lowest set bit
  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        idx   = OUT_W'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/vstep_side.sv
module vstep_side #(
  parameter int ELEMS  = 64,
  parameter int STEP_W = 7,
  parameter int SUB_W  = 2
) (
  input  logic [ELEMS-1:0]  eff,
  input  logic [STEP_W-1:0] cur_step,
  input  logic [SUB_W-1:0]  cur_sub,
  input  logic [SUB_W-1:0]  sub_last,
  input  logic              swap,
  output logic [STEP_W-1:0] nxt_step,
  output logic [SUB_W-1:0]  nxt_sub,
  output logic              wrap
);
  logic [ELEMS-1:0]  above;
  logic [STEP_W-1:0] first_idx, above_idx, elem_step;
  logic              any, has_above, sub_end;

  always_comb begin
    for (int i = 0; i < ELEMS; i++) begin
      above[i] = eff[i] && (STEP_W'(i) > cur_step);
    end
  end

  vstep_prio #(.W(ELEMS), .OUT_W(STEP_W)) i_first (
    .vec(eff), .idx(first_idx), .found(any)
  );
  vstep_prio #(.W(ELEMS), .OUT_W(STEP_W)) i_above (
    .vec(above), .idx(above_idx), .found(has_above)
  );

  always_comb begin
    elem_step = has_above ? above_idx : first_idx;
    sub_end   = (cur_sub >= sub_last);
    nxt_step  = cur_step;
    nxt_sub   = cur_sub;
    wrap      = 1'b0;
    if (!any) begin
      nxt_step = '0;
      nxt_sub  = '0;
      wrap     = 1'b1;
    end else if (!swap) begin
      if (!sub_end) begin
        nxt_sub = cur_sub + 1'b1;
      end else begin
        nxt_sub  = '0;
        nxt_step = elem_step;
        wrap     = !has_above;
      end
    end else begin
      nxt_step = elem_step;
      if (!has_above) begin
        nxt_sub = sub_end ? '0 : cur_sub + 1'b1;
        wrap    = sub_end;
      end
    end
  end
endmodule

// File: rtl/vstep_unit.sv
module vstep_unit #(
  parameter int XLEN   = 64,
  parameter int ELEMS  = 64,
  parameter int STEP_W = 7,
  parameter int SUB_W  = 2,
  parameter int NSHAPE = 4,
  parameter int MODE_W = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic [MODE_W-1:0]        cmd_mode,
  input  logic                     cmd_commit,
  input  logic                     cmd_record,
  input  logic [STEP_W-1:0]        cmd_vec_len,
  input  logic [ELEMS-1:0]         cmd_pred,
  input  logic [SUB_W-1:0]         cmd_sub_len,
  input  logic [NSHAPE*STEP_W-1:0] shape_idx,
  output logic                     res_valid,
  input  logic                     res_ready,
  output logic [XLEN-1:0]          res_data,
  output logic [3:0]               res_cr,
  output logic                     res_cr_vld,
  output logic                     res_end,
  output logic [STEP_W-1:0]        src_step,
  output logic [STEP_W-1:0]        dst_step,
  output logic [SUB_W-1:0]         src_sub,
  output logic [SUB_W-1:0]         dst_sub,
  output logic                     pack_flag,
  output logic                     unpack_flag
);
  import vstep_pkg::*;

  localparam int SEL_W = (NSHAPE > 1) ? $clog2(NSHAPE) : 1;

  logic [STEP_W-1:0] step_q [2];
  logic [SUB_W-1:0]  sub_q  [2];
  logic [STEP_W-1:0] nstep  [2];
  logic [SUB_W-1:0]  nsub   [2];
  logic [1:0]        wrap;
  logic              pack_q, unpack_q;
  logic [ELEMS-1:0]  eff_mask;

  vstep_kind_e       kind;
  logic [SEL_W-1:0]  sel;
  logic [XLEN-1:0]   res_n;
  logic              end_n, emit, upd_steps, upd_flags, fire;

  // available elements: predicate set and index below the vector length
  always_comb begin
    for (int i = 0; i < ELEMS; i++) begin
      eff_mask[i] = cmd_pred[i] && (STEP_W'(i) < cmd_vec_len);
    end
  end

  // side 0 is the source (ordered by unpack), side 1 the destination (by pack)
  for (genvar s = 0; s < 2; s++) begin : g_side
    vstep_side #(.ELEMS(ELEMS), .STEP_W(STEP_W), .SUB_W(SUB_W)) i_side (
      .eff      (eff_mask),
      .cur_step (step_q[s]),
      .cur_sub  (sub_q[s]),
      .sub_last (cmd_sub_len),
      .swap     ((s == 0) ? unpack_q : pack_q),
      .nxt_step (nstep[s]),
      .nxt_sub  (nsub[s]),
      .wrap     (wrap[s])
    );
  end

  // mode decode
  always_comb begin
    sel = SEL_W'(cmd_mode - MODE_W'(1));
    if (cmd_mode == '0)                                         kind = K_STEP;
    else if (cmd_mode <= MODE_W'(NSHAPE))                       kind = K_SHAPE;
    else if (cmd_mode == MODE_W'(NSHAPE + 1))                   kind = K_SRC;
    else if (cmd_mode == MODE_W'(NSHAPE + 2))                   kind = K_DST;
    else if (cmd_mode[MODE_W-1:2] == (MODE_W-2)'(3))            kind = K_FLAGS;
    else                                                        kind = K_OTHER;
  end

  always_comb begin
    res_n     = '0;
    end_n     = 1'b0;
    emit      = 1'b1;
    upd_steps = 1'b0;
    upd_flags = 1'b0;
    case (kind)
      K_STEP: begin
        res_n     = XLEN'(nstep[0]);
        end_n     = |wrap;
        upd_steps = cmd_commit;
        emit      = cmd_commit | cmd_record;
      end
      K_SHAPE: res_n = XLEN'(shape_idx[sel*STEP_W +: STEP_W]);
      K_SRC:   res_n = XLEN'(step_q[0]);
      K_DST:   res_n = XLEN'(step_q[1]);
      K_FLAGS: begin
        res_n     = XLEN'(cmd_mode[1:0]);
        upd_flags = 1'b1;
      end
      default: res_n = '0;
    endcase
  end

  assign cmd_ready = !res_valid || res_ready;
  assign fire      = cmd_valid && cmd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_data   <= '0;
      res_cr     <= '0;
      res_cr_vld <= 1'b0;
      res_end    <= 1'b0;
      pack_q     <= 1'b0;
      unpack_q   <= 1'b0;
      for (int s = 0; s < 2; s++) begin
        step_q[s] <= '0;
        sub_q[s]  <= '0;
      end
    end else begin
      if (fire) begin
        res_valid <= emit;
      end else if (res_ready) begin
        res_valid <= 1'b0;
      end
      if (fire && emit) begin
        res_data   <= res_n;
        res_cr     <= mk_cr(64'(res_n), end_n);
        res_cr_vld <= cmd_record;
        res_end    <= end_n;
      end
      if (fire && upd_steps) begin
        for (int s = 0; s < 2; s++) begin
          step_q[s] <= nstep[s];
          sub_q[s]  <= nsub[s];
        end
      end
      if (fire && upd_flags) begin
        pack_q   <= cmd_mode[0];
        unpack_q <= cmd_mode[1];
      end
    end
  end

  assign src_step    = step_q[0];
  assign dst_step    = step_q[1];
  assign src_sub     = sub_q[0];
  assign dst_sub     = sub_q[1];
  assign pack_flag   = pack_q;
  assign unpack_flag = unpack_q;
endmodule

// File: rtl/vstep_chk.sv
module vstep_chk #(
  parameter int XLEN   = 64,
  parameter int STEP_W = 7,
  parameter int SUB_W  = 2,
  parameter int MODE_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [MODE_W-1:0] cmd_mode,
  input logic              cmd_commit,
  input logic              cmd_record,
  input logic              res_valid,
  input logic              res_ready,
  input logic [XLEN-1:0]   res_data,
  input logic [3:0]        res_cr,
  input logic              res_cr_vld,
  input logic              res_end,
  input logic [STEP_W-1:0] src_step,
  input logic [STEP_W-1:0] dst_step,
  input logic [SUB_W-1:0]  src_sub,
  input logic [SUB_W-1:0]  dst_sub,
  input logic              pack_flag,
  input logic              unpack_flag
);
  logic acc;
  assign acc = cmd_valid && cmd_ready;

  AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_mode[MODE_W-1:2] == (MODE_W-2)'(3)
    |=> pack_flag == $past(cmd_mode[0]) && unpack_flag == $past(cmd_mode[1])); // R1

  AST_PEEK_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_mode == '0 && !cmd_commit
    |=> $stable(src_step) && $stable(dst_step) && $stable(src_sub) && $stable(dst_sub)); // R5

  AST_NOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_mode == '0 && !cmd_commit && !cmd_record |=> !res_valid); // R6

  AST_RESULT_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_data[XLEN-1:STEP_W] == '0); // R8

  AST_CR_ZERO_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_cr_vld |-> res_cr[1] == (res_data == '0) && res_cr[0] == res_end); // R9

  AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(res_cr) && $stable(res_end)); // R10

  AST_NO_ACCEPT_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |-> !cmd_ready); // R10
endmodule

bind vstep_unit vstep_chk #(
  .XLEN(XLEN), .STEP_W(STEP_W), .SUB_W(SUB_W), .MODE_W(MODE_W)
) i_vstep_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_mode(cmd_mode), .cmd_commit(cmd_commit), .cmd_record(cmd_record),
  .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
  .res_cr(res_cr), .res_cr_vld(res_cr_vld), .res_end(res_end),
  .src_step(src_step), .dst_step(dst_step), .src_sub(src_sub), .dst_sub(dst_sub),
  .pack_flag(pack_flag), .unpack_flag(unpack_flag)
);

// File: tb/test_vstep_unit.sv
module test_vstep_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [6:0]  cmd_mode = '0;
  logic        cmd_commit = 1'b0;
  logic        cmd_record = 1'b0;
  logic [6:0]  cmd_vec_len = 7'd8;
  logic [63:0] cmd_pred = '1;
  logic [1:0]  cmd_sub_len = '0;
  logic [27:0] shape_idx = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [63:0] res_data;
  logic [3:0]  res_cr;
  logic        res_cr_vld;
  logic        res_end;
  logic [6:0]  src_step, dst_step;
  logic [1:0]  src_sub, dst_sub;
  logic        pack_flag, unpack_flag;

  int n_cmp = 0;
  int n_bad = 0;
  int ms, md, mss, mds;
  bit mp, mu;

  vstep_unit i_vstep_unit (.*);

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cmd_valid = 1'b0; res_ready = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    ms = 0; md = 0; mss = 0; mds = 0; mp = 0; mu = 0;
  endtask

  task automatic do_cmd(input logic [6:0] m, input logic c, input logic r);
    @(negedge clk);
    cmd_mode = m; cmd_commit = c; cmd_record = r; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // independent model of one side's walk
  task automatic madv(input int step, input int sub, input bit swap,
                      output int nstep, output int nsub, output bit wr);
    int first = -1;
    int nxt = -1;
    int last = cmd_sub_len;
    for (int i = 0; i < 64; i++) begin
      if (cmd_pred[i] && i < cmd_vec_len) begin
        if (first < 0) first = i;
        if (i > step && nxt < 0) nxt = i;
      end
    end
    nstep = step; nsub = sub; wr = 0;
    if (first < 0) begin
      nstep = 0; nsub = 0; wr = 1;
    end else if (!swap) begin
      if (sub < last) nsub = sub + 1;
      else begin
        nsub = 0; nstep = (nxt >= 0) ? nxt : first; wr = (nxt < 0);
      end
    end else begin
      nstep = (nxt >= 0) ? nxt : first;
      if (nxt < 0) begin
        if (sub < last) nsub = sub + 1;
        else begin nsub = 0; wr = 1; end
      end
    end
  endtask

  task automatic mstep(input bit c, input bit r, input string tag);
    int ns, nd, nss, nds;
    bit ws, wd;
    madv(ms, mss, mu, ns, nss, ws);
    madv(md, mds, mp, nd, nds, wd);
    do_cmd(7'd0, c, r);
    check({tag, " R8 step result"}, res_data, 64'(ns));
    check({tag, " R4 end"}, {63'd0, res_end}, {63'd0, ws | wd});
    if (c) begin
      ms = ns; md = nd; mss = nss; mds = nds;
    end
    check({tag, " R2 src_step"}, 64'(src_step), 64'(ms));
    check({tag, " R2 dst_step"}, 64'(dst_step), 64'(md));
    check({tag, " R2 src_sub"}, 64'(src_sub), 64'(mss));
    check({tag, " R2 dst_sub"}, 64'(dst_sub), 64'(mds));
  endtask

  task automatic t_reset();
    do_reset();
    check("R11 res_valid", {63'd0, res_valid}, 64'd0);
    check("R11 steps", {50'd0, src_step, dst_step}, 64'd0);
    check("R11 subs/flags", {58'd0, src_sub, dst_sub, pack_flag, unpack_flag}, 64'd0);
  endtask

  task automatic t_flags();
    do_reset();
    for (int m = 12; m < 16; m++) begin
      do_cmd(7'(m), m[0], 1'b0);
      check("R1 flag result", res_data, 64'(m & 3));
      check("R1 pack", {63'd0, pack_flag}, 64'(m & 1));
      check("R1 unpack", {63'd0, unpack_flag}, 64'((m >> 1) & 1));
    end
  endtask

  task automatic t_query();
    do_reset();
    shape_idx = {7'd99, 7'd63, 7'd17, 7'd5};
    cmd_pred = '1; cmd_vec_len = 7'd8; cmd_sub_len = 2'd0;
    do_cmd(7'd1, 1'b0, 1'b0); check("R7 shape0", res_data, 64'd5);
    do_cmd(7'd2, 1'b1, 1'b0); check("R7 shape1", res_data, 64'd17);
    do_cmd(7'd3, 1'b0, 1'b0); check("R7 shape2", res_data, 64'd63);
    do_cmd(7'd4, 1'b1, 1'b0); check("R7 shape3", res_data, 64'd99);
    for (int k = 0; k < 3; k++) mstep(1'b1, 1'b0, "R3 query prep");
    do_cmd(7'd5, 1'b1, 1'b0); check("R7 src query", res_data, 64'd3);
    do_cmd(7'd6, 1'b0, 1'b0); check("R7 dst query", res_data, 64'd3);
    do_cmd(7'd7, 1'b1, 1'b0);  check("R7 mode7 zero", res_data, 64'd0);
    do_cmd(7'h1c, 1'b1, 1'b0); check("R7 high flag-like zero", res_data, 64'd0);
    check("R7 flags untouched", {62'd0, pack_flag, unpack_flag}, 64'd0);
    check("R7 state untouched", 64'(src_step), 64'd3);
  endtask

  task automatic t_walk();
    do_reset();
    cmd_pred = '1; cmd_vec_len = 7'd4; cmd_sub_len = 2'd0;
    for (int k = 0; k < 5; k++) mstep(1'b1, 1'b0, "R2 walk");
  endtask

  task automatic t_skip();
    do_reset();
    cmd_pred = 64'h92; cmd_vec_len = 7'd8; cmd_sub_len = 2'd0;
    for (int k = 0; k < 5; k++) mstep(1'b1, 1'b0, "R3 skip");
    cmd_vec_len = 7'd5;
    for (int k = 0; k < 3; k++) mstep(1'b1, 1'b0, "R3 short vl");
  endtask

  task automatic t_sub();
    do_reset();
    cmd_pred = 64'h7; cmd_vec_len = 7'd3; cmd_sub_len = 2'd1;
    do_cmd(7'd14, 1'b0, 1'b0); mu = 1; mp = 0;
    check("R1 unpack set", {62'd0, pack_flag, unpack_flag}, 64'd1);
    for (int k = 0; k < 7; k++) mstep(1'b1, 1'b0, "R2 unpack order");
    do_cmd(7'd13, 1'b0, 1'b0); mu = 0; mp = 1;
    cmd_sub_len = 2'd2;
    for (int k = 0; k < 10; k++) mstep(1'b1, 1'b0, "R2 pack order");
  endtask

  task automatic t_peek_nop();
    do_reset();
    cmd_pred = '1; cmd_vec_len = 7'd8; cmd_sub_len = 2'd0;
    mstep(1'b1, 1'b0, "R2 peek prep");
    mstep(1'b0, 1'b1, "R5 peek");
    check("R5 peek result", res_data, 64'd2);
    do_cmd(7'd0, 1'b0, 1'b0);
    check("R6 nop no beat", {63'd0, res_valid}, 64'd0);
    check("R6 nop state", 64'(src_step), 64'd1);
  endtask

  task automatic t_empty_record();
    do_reset();
    cmd_pred = '1; cmd_vec_len = 7'd8; cmd_sub_len = 2'd0;
    mstep(1'b1, 1'b1, "R9 prep");
    check("R9 cr positive", {60'd0, res_cr}, 64'b0100);
    check("R9 cr valid", {63'd0, res_cr_vld}, 64'd1);
    mstep(1'b1, 1'b0, "R4 prep");
    cmd_pred = '0;
    mstep(1'b1, 1'b1, "R4 empty");
    check("R9 cr zero+end", {60'd0, res_cr}, 64'b0011);
    cmd_pred = '1; cmd_vec_len = 7'd0;
    mstep(1'b1, 1'b0, "R4 zero vl");
    do_cmd(7'd5, 1'b0, 1'b0);
    check("R9 no cr requested", {63'd0, res_cr_vld}, 64'd0);
    check("R4 end only for stepping", {63'd0, res_end}, 64'd0);
  endtask

  task automatic t_backpressure();
    do_reset();
    cmd_pred = '1; cmd_vec_len = 7'd8; cmd_sub_len = 2'd0;
    @(negedge clk);
    res_ready = 1'b0;
    cmd_mode = 7'd0; cmd_commit = 1'b1; cmd_record = 1'b0; cmd_valid = 1'b1;
    @(negedge clk);
    check("R10 first beat", res_data, 64'd1);
    check("R10 ready low", {63'd0, cmd_ready}, 64'd0);
    repeat (2) @(negedge clk);
    check("R10 beat held", res_data, 64'd1);
    check("R10 valid held", {63'd0, res_valid}, 64'd1);
    check("R10 second not taken", 64'(src_step), 64'd1);
    res_ready = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R10 drain+accept valid", {63'd0, res_valid}, 64'd1);
    check("R10 second beat", res_data, 64'd2);
    check("R10 second step", 64'(src_step), 64'd2);
    @(negedge clk);
    check("R10 empties", {63'd0, res_valid}, 64'd0);
  endtask

  initial begin
    t_reset();
    t_flags();
    t_query();
    t_walk();
    t_skip();
    t_sub();
    t_peek_nop();
    t_empty_record();
    t_backpressure();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule